// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block is a clocked, synthesizable stand-in for a 16-bit static RAM that is normally driven by active-low strobes. A host presents a chip select, an output enable, a write strobe and one enable per byte, together with a word address and write data. Once per clock the block decodes these into a mode, moves data between the bus and its storage, and reports which byte lanes it would drive onto a shared bus.

There are no tri-state signals. The shared bus is split into a write-data input, a read-data output and a two-bit lane-drive output. Each lane is handled on its own for both reads and writes. A write is committed when the write condition of that lane ends, so the value stored is the last one presented while the lane was writing. The storage depth is a parameter and the address folds onto it, so a shallow array can stand in for the full address space during simulation.

Top module: `sram_emu`

## Requirements
- R1: With `cs_n`=0, `we_n`=0 and both byte enables low, both bytes of `wdata` are stored at `addr`. The level of `oe_n` has no effect. A later read of `addr` returns the stored word.
- R2: While writing, bits 7:0 are stored only if `lo_n`=0 and bits 15:8 only if `hi_n`=0. A lane whose enable is high keeps its old contents. With both enables high, nothing is stored.
- R3: `lane_drive[0]` is 1 exactly when `cs_n`=0, `oe_n`=0, `we_n`=1 and `lo_n`=0. `lane_drive[1]` follows the same rule with `hi_n`. A driven lane of `rdata` shows the stored byte, and an undriven lane reads as zero.
- R4: While `cs_n`=0 and `we_n`=0, `lane_drive` is 2'b00, even when `oe_n`=0.
- R5: While `cs_n`=1, `standby` is 1, `lane_drive` is 2'b00 and `mode` is 0. Every other input is ignored, and no write takes place.
- R6: `mode` encodes the decoded row: 0 deselected, 1 read both, 2 read low, 3 read high, 4 write both, 5 write low, 6 write high, 7 selected with no data transfer (either `oe_n`=1 while reading, or both byte enables high).
- R7: A lane's write ends in the first cycle in which `cs_n`, `we_n` or that lane's enable is high. The byte stored is the one from `wdata` and the address is the one from `addr` in the last cycle the lane was writing.
- R8: A read in the cycle right after a write ends, at the same address, returns the newly written byte.
- R9: Only the low log2(DEPTH) address bits select a word, so `addr` and `addr`+DEPTH refer to the same word.
- R10: While `rst_n` is low and after its release, the block starts with no write in progress. With `cs_n`=1 it reports `standby`=1 and `mode`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset of the write tracking |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| lo_n | input | 1 | Low byte (bits 7:0) enable, active low |
| hi_n | input | 1 | High byte (bits 15:8) enable, active low |
| addr | input | ADDR_W (20) | Word address |
| wdata | input | DATA_W (16) | Write data half of the bus |
| rdata | output | DATA_W (16) | Read data half of the bus, zero on undriven lanes |
| lane_drive | output | 2 | Per-lane bus drive indication |
| mode | output | 3 | Decoded control row |
| standby | output | 1 | Low-power deselected state |

## Verification
The bench targets writes whose data changes while the strobe is held low. A design that captures data on the leading edge, or on every active cycle straight into storage, stores the wrong byte there. It ends one lane early by raising only that byte enable while the strobe stays low, which catches a design that ends both lanes on the shared strobe alone. It reads in the cycle after a write ends, which exposes a missing bypass as stale data. It reads through aliased addresses, which exposes a design that uses the upper bits. Write attempts with `oe_n` low, or with chip select high, catch a design that drives the bus during a write or stores while deselected.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
   localparam int LANE_W = 8;
   localparam int LANES  = 2;

   typedef enum logic [2:0] {
      MODE_IDLE    = 3'd0,
      MODE_RD_BOTH = 3'd1,
      MODE_RD_LO   = 3'd2,
      MODE_RD_HI   = 3'd3,
      MODE_WR_BOTH = 3'd4,
      MODE_WR_LO   = 3'd5,
      MODE_WR_HI   = 3'd6,
      MODE_QUIET   = 3'd7
   } sram_mode_e;
endpackage

// File: rtl/sram_ctl_decode.sv
module sram_ctl_decode
   import sram_emu_pkg::*;
(
   input  logic             cs_n,
   input  logic             oe_n,
   input  logic             we_n,
   input  logic [LANES-1:0] lane_n,
   output sram_mode_e       mode,
   output logic [LANES-1:0] lane_wr,
   output logic [LANES-1:0] lane_rd,
   output logic             standby
);
   logic [LANES-1:0] lane_on;
   assign lane_on = ~lane_n;

   always_comb begin
      lane_wr = '0;
      lane_rd = '0;
      standby = 1'b0;
      mode    = MODE_QUIET;
      if (cs_n) begin
         standby = 1'b1;
         mode    = MODE_IDLE;
      end else if (!we_n) begin
         lane_wr = lane_on;
         case (lane_on)
            2'b11:   mode = MODE_WR_BOTH;
            2'b01:   mode = MODE_WR_LO;
            2'b10:   mode = MODE_WR_HI;
            default: mode = MODE_QUIET;
         endcase
      end else if (!oe_n) begin
         lane_rd = lane_on;
         case (lane_on)
            2'b11:   mode = MODE_RD_BOTH;
            2'b01:   mode = MODE_RD_LO;
            2'b10:   mode = MODE_RD_HI;
            default: mode = MODE_QUIET;
         endcase
      end
   end
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
   parameter int W      = 8,
   parameter int DEPTH  = 1024,
   parameter bit BYPASS = 1'b1,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_act,
   input  logic [IDX_W-1:0] idx,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     rdata
);
   logic [W-1:0]     mem [DEPTH];
   logic             prev_act;
   logic [IDX_W-1:0] stage_idx;
   logic [W-1:0]     stage_dat;
   logic             commit;

   assign commit = prev_act & ~wr_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_act <= 1'b0;
      else        prev_act <= wr_act;
   end

   always_ff @(posedge clk) begin
      if (wr_act) begin
         stage_idx <= idx;
         stage_dat <= wdata;
      end
      if (commit) mem[stage_idx] <= stage_dat;
   end

   generate
      if (BYPASS) begin : g_bypass
         assign rdata = (commit && idx == stage_idx) ? stage_dat : mem[idx];
      end else begin : g_direct
         assign rdata = mem[idx];
      end
   endgenerate

   assert_stage_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_act && !$past(wr_act)) |=> $stable(stage_dat));
   assert_commit_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> mem[$past(stage_idx)] == $past(stage_dat));
endmodule

// File: rtl/sram_emu.sv
module sram_emu
   import sram_emu_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 16,
   parameter int DEPTH  = 1024,
   parameter bit BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              lo_n,
   input  logic              hi_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        lane_drive,
   output logic [2:0]        mode,
   output logic              standby
);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (DATA_W != LANES * LANE_W) begin : g_bad_width
         $error("sram_emu: DATA_W must equal two byte lanes");
      end
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
         $error("sram_emu: DEPTH must be a power of two of at least 2");
      end
      if (IDX_W > ADDR_W) begin : g_bad_addr
         $error("sram_emu: DEPTH exceeds the address space");
      end
   endgenerate

   sram_mode_e       dec_mode;
   logic [LANES-1:0] lane_wr;
   logic [LANES-1:0] lane_rd;
   logic [IDX_W-1:0] idx;

   sram_ctl_decode u_dec (
      .cs_n    (cs_n),
      .oe_n    (oe_n),
      .we_n    (we_n),
      .lane_n  ({hi_n, lo_n}),
      .mode    (dec_mode),
      .lane_wr (lane_wr),
      .lane_rd (lane_rd),
      .standby (standby)
   );

   assign idx = addr[IDX_W-1:0];

   generate
      if (IDX_W < ADDR_W) begin : g_fold
         logic unused_hi_bits;
         assign unused_hi_bits = ^addr[ADDR_W-1:IDX_W];
      end
   endgenerate

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LANE_W-1:0] bank_q;
         sram_lane_bank #(
            .W      (LANE_W),
            .DEPTH  (DEPTH),
            .BYPASS (BYPASS)
         ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_act (lane_wr[g]),
            .idx    (idx),
            .wdata  (wdata[g*LANE_W +: LANE_W]),
            .rdata  (bank_q)
         );
         assign rdata[g*LANE_W +: LANE_W] = lane_rd[g] ? bank_q : '0;
      end
   endgenerate

   assign lane_drive = lane_rd;
   assign mode       = dec_mode;

   assert_write_floats_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !we_n) |-> lane_drive == 2'b00);
   assert_standby_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (standby && lane_drive == 2'b00 && mode == 3'd0));
   assert_drive_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_drive != 2'b00) |-> (!cs_n && !oe_n && we_n));
   assert_idle_lanes_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_drive == 2'b00) |-> rdata == '0);
   assert_write_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode >= 3'd4 && mode <= 3'd6) |-> (!we_n && !cs_n));
endmodule

// File: tb/tb_sram_emu.sv
module tb_sram_emu;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, lo_n = 1'b1, hi_n = 1'b1;
   logic [19:0] addr = '0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  lane_drive;
   logic [2:0]  mode;
   logic        standby;

   int checks = 0, fails = 0;
   logic [15:0] emem [DEPTH];
   bit   pv [2];
   int   pa [2];
   logic [7:0] pd [2];
   logic [15:0] got;

   always #10 clk = ~clk;

   sram_emu #(.ADDR_W(20), .DATA_W(16), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
      .lo_n(lo_n), .hi_n(hi_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .lane_drive(lane_drive), .mode(mode), .standby(standby)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_mode(bit cs, bit oe, bit we, bit lo, bit hi);
      logic [1:0] on;
      on = {~hi, ~lo};
      if (cs) return 3'd0;
      if (!we) return (on == 2'b11) ? 3'd4 : (on == 2'b01) ? 3'd5 : (on == 2'b10) ? 3'd6 : 3'd7;
      if (oe) return 3'd7;
      return (on == 2'b11) ? 3'd1 : (on == 2'b01) ? 3'd2 : (on == 2'b10) ? 3'd3 : 3'd7;
   endfunction

   task automatic step(input bit cs, input bit oe, input bit we, input bit lo,
                       input bit hi, input logic [19:0] a, input logic [15:0] d);
      bit act [2];
      bit rd  [2];
      bit ln  [2];
      int ix;
      logic [1:0]  edrv;
      logic [15:0] edat;
      string rq;
      @(negedge clk);
      cs_n = cs; oe_n = oe; we_n = we; lo_n = lo; hi_n = hi; addr = a; wdata = d;
      #2;
      ix = int'(a) % DEPTH;
      ln[0] = lo; ln[1] = hi;
      edat = '0;
      for (int i = 0; i < 2; i++) begin
         act[i] = !cs && !we && !ln[i];
         rd[i]  = !cs && !oe && we && !ln[i];
         if (pv[i] && !act[i]) begin
            emem[pa[i]][i*8 +: 8] = pd[i];
            pv[i] = 1'b0;
         end
         edrv[i] = rd[i];
         if (rd[i]) edat[i*8 +: 8] = emem[ix][i*8 +: 8];
      end
      rq = cs ? "R5" : (!we ? "R4" : "R3");
      chk({"R6 mode ", rq}, 32'(mode), 32'(exp_mode(cs, oe, we, lo, hi)));
      chk({"drive ", rq}, 32'(lane_drive), 32'(edrv));
      chk("R3/R7/R8 rdata", 32'(rdata), 32'(edat));
      chk("R5 standby", 32'(standby), 32'(cs));
      got = rdata;
      for (int i = 0; i < 2; i++)
         if (act[i]) begin
            pv[i] = 1'b1; pa[i] = ix; pd[i] = d[i*8 +: 8];
         end
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) emem[i] = '0;
      pv[0] = 0; pv[1] = 0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #3;
      chk("R10 standby in reset", 32'(standby), 32'd1);
      chk("R10 mode in reset", 32'(mode), 32'd0);
      rst_n = 1'b1;

      // Preload the model-known contents of the small array.
      for (int i = 0; i < DEPTH; i++) begin
         step(0, 1, 0, 0, 0, 20'(i), 16'(i * 16'h0101));
         step(0, 1, 1, 1, 1, 20'(i), 16'h0);
      end
      step(1, 1, 1, 1, 1, 20'h0, 16'h0);
      chk("R10 standby after reset", 32'(standby), 32'd1);

      // R1 / R4 / R8: write with oe low, read back at once and later
      step(0, 0, 0, 0, 0, 20'd5, 16'hA55A);
      chk("R4 no drive during write", 32'(lane_drive), 32'd0);
      step(0, 0, 1, 0, 0, 20'd5, 16'h0);
      chk("R8 read right after write", 32'(got), 32'hA55A);
      step(1, 1, 1, 1, 1, 20'd0, 16'h0);
      step(0, 0, 1, 0, 0, 20'd5, 16'h0);
      chk("R1 read back", 32'(got), 32'hA55A);

      // R2: single-lane writes and a write with no lane
      step(0, 1, 0, 0, 1, 20'd5, 16'h1234);
      step(0, 0, 1, 0, 0, 20'd5, 16'h0);
      chk("R2 low lane only", 32'(got), 32'hA534);
      step(0, 1, 0, 1, 0, 20'd5, 16'hBEEF);
      step(0, 0, 1, 0, 0, 20'd5, 16'h0);
      chk("R2 high lane only", 32'(got), 32'hBE34);
      step(0, 1, 0, 1, 1, 20'd5, 16'h0000);
      step(0, 0, 1, 0, 0, 20'd5, 16'h0);
      chk("R2 no lane stores nothing", 32'(got), 32'hBE34);
      step(0, 0, 1, 1, 0, 20'd5, 16'h0);
      chk("R3 high lane only driven", 32'(lane_drive), 32'd2);
      chk("R3 undriven low lane zero", 32'(got), 32'hBE00);

      // R7: data changes while held, last value wins
      step(0, 1, 0, 0, 0, 20'd9, 16'h1111);
      step(0, 1, 0, 0, 0, 20'd9, 16'h2222);
      step(0, 1, 0, 0, 0, 20'd9, 16'h3333);
      step(0, 0, 1, 0, 0, 20'd9, 16'h0);
      chk("R7 last data stored", 32'(got), 32'h3333);
      // R7: high lane ends first on its own enable
      step(0, 1, 0, 0, 0, 20'd10, 16'h4455);
      step(0, 1, 0, 0, 1, 20'd10, 16'h6677);
      step(0, 1, 1, 1, 1, 20'd10, 16'h0);
      step(0, 0, 1, 0, 0, 20'd10, 16'h0);
      chk("R7 per-lane terminating edge", 32'(got), 32'h4477);

      // R5: writes while deselected are ignored
      step(1, 0, 0, 0, 0, 20'd9, 16'hFFFF);
      step(1, 0, 0, 0, 0, 20'd9, 16'hFFFF);
      step(0, 0, 1, 0, 0, 20'd9, 16'h0);
      chk("R5 deselected write ignored", 32'(got), 32'h3333);

      // R9: address folding
      step(0, 1, 0, 0, 0, 20'd3, 16'h0C0C);
      step(0, 1, 1, 1, 1, 20'd3, 16'h0);
      step(0, 0, 1, 0, 0, 20'(3 + DEPTH), 16'h0);
      chk("R9 alias read", 32'(got), 32'h0C0C);
      step(0, 1, 0, 0, 0, 20'(DEPTH * 5 + 7), 16'h7777);
      step(0, 1, 1, 1, 1, 20'd0, 16'h0);
      step(0, 0, 1, 0, 0, 20'd7, 16'h0);
      chk("R9 alias write", 32'(got), 32'h7777);

      // Random mix against the model
      for (int n = 0; n < 4000; n++) begin
         logic [19:0] ra;
         ra = 20'($urandom_range(0, 15));
         if ($urandom_range(0, 3) == 0) ra = ra + 20'(DEPTH * $urandom_range(1, 100));
         step($urandom_range(0, 7) == 0, $urandom_range(0, 2) == 0,
              $urandom_range(0, 1) == 0, $urandom_range(0, 3) == 0,
              $urandom_range(0, 3) == 0, ra, 16'($urandom));
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule